// File: doc/BRIEF.md
# Serial Row Loader with Frame Store

This block takes 32-bit command words that arrive one bit at a time on a serial data pin, timed by a serial clock, and acts on each word when a separate strobe pin rises. Each committed word names a row of a small frame store, carries twenty pixel bits for that row, and carries a four-bit brightness code that is kept in a holding register for the dimming logic further down the display path.

The frame store has twenty rows of twenty bits. Its write side belongs only to the loader. Its read side is a combinational port that the scan logic can address at any moment, so rows can be read out continuously while new words are being shifted in.

Everything runs in the serial clock domain. The strobe is sampled on the rising serial clock edge, and a commit happens on the first edge at which the strobe is seen high after having been seen low. Reset is synchronous and active low.

Top module: `serial_row_loader`

## Requirements
- R1: On every rising edge of `sclk` the block shifts in one bit from `sdata`, most significant bit first; a commit uses the last 32 bits shifted in before the commit edge, so any extra bits sent earlier have no effect.
- R2: Within the committed word, bits [31:27] are the row address, bits [26:7] are the row data (bit 26 lands in `rd_data[19]`), bits [6:3] are the brightness code and bits [2:0] are ignored.
- R3: A commit happens at the rising `sclk` edge where `strobe` is high and was low at the previous edge; for a row address from 0 to 19 the data field is written to that row and is visible on `rd_data` right after that edge.
- R4: On every commit the brightness code is loaded into `bright`; between commits `bright` does not change.
- R5: Holding `strobe` high over many edges gives exactly one commit; words shifted in while it stays high change neither the frame store nor `bright`.
- R6: A row address from 20 to 31 writes no row, but the brightness code of that word is still loaded.
- R7: `rd_data` shows the row selected by `rd_addr` combinationally at all times, unchanged while bits are being shifted in; a `rd_addr` of 20 to 31 reads as zero.
- R8: While `rst_n` is low at a rising `sclk` edge, all rows and `bright` are cleared to zero.
- R9: A commit changes only the addressed row; every other row keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sdata | input | 1 | Serial command bit, MSB first |
| strobe | input | 1 | Commit strobe; its rising edge commits the word |
| rd_addr | input | 5 | Read row select for the scan logic |
| rd_data | output | 20 | Contents of the selected row |
| bright | output | 4 | Brightness code of the last committed word |

## Verification
The bench aims at the first and last rows, at addresses just past the end of the store (where a design that wrote anyway would corrupt a row or alias onto row 0 through 19), and at a strobe held high while a second word streams in, which a level-triggered design would commit twice. Junk in the three unused bits and extra leading bits before a word catch a shift register that is misordered, too short or decoded at the wrong offsets. Between commits it keeps reading a fixed row while bits stream in, so a store that leaked the shift register onto its read port shows up, and a mid-run reset must return every row and the brightness code to zero.

// File: rtl/srl_pkg.sv
// Shared constants and field layout for the serial row loader.
// Assumes a fixed command word of 32 bits; field offsets are derived here.
package srl_pkg;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 20;
    localparam int BRIGHT_W = 4;
    localparam int ROWS     = 20;

    localparam int ADDR_LSB   = WORD_W - ADDR_W;
    localparam int DATA_LSB   = ADDR_LSB - DATA_W;
    localparam int BRIGHT_LSB = DATA_LSB - BRIGHT_W;

    typedef struct packed {
        logic [ADDR_W-1:0]   row;
        logic [DATA_W-1:0]   pixels;
        logic [BRIGHT_W-1:0] level;
    } cmd_t;

    // Pull the used fields out of a raw command word; low spare bits dropped.
    function automatic cmd_t split_word(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.row    = w[ADDR_LSB   +: ADDR_W];
        c.pixels = w[DATA_LSB   +: DATA_W];
        c.level  = w[BRIGHT_LSB +: BRIGHT_W];
        return c;
    endfunction
endpackage

// File: rtl/srl_shift.sv
// Serial-in shift register for command words.
// Shifts one bit per rising clock, MSB first, continuously; the consumer
// decides when the contents are meaningful. Synchronous active-low reset.
module srl_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         din,
    output logic [W-1:0] word
);
    logic [W-1:0] sr_q;

    // Move the register up one place and take the new bit at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[W-2:0], din};
    end

    assign word = sr_q;
endmodule

// File: rtl/srl_commit.sv
// Commit stage: detects the strobe's rising edge in the serial clock domain,
// decodes the shifted word and issues at most one store write per rising edge.
// Also holds the brightness code. Assumes strobe is synchronous to clk.
module srl_commit
    import srl_pkg::*;
#(
    parameter int NROWS = ROWS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe,
    input  logic [WORD_W-1:0]   word,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic [BRIGHT_W-1:0] bright
);
    logic                strobe_q;
    logic                commit;
    logic [BRIGHT_W-1:0] bright_q;
    cmd_t                cmd;

    assign cmd     = split_word(word);
    assign commit  = strobe && !strobe_q;
    assign wr_en   = commit && (int'(cmd.row) < NROWS);
    assign wr_addr = cmd.row;
    assign wr_data = cmd.pixels;
    assign bright  = bright_q;

    // Remember the strobe level of the previous edge for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Load the brightness code on every commit, in range or not.
    always_ff @(posedge clk) begin
        if (!rst_n)      bright_q <= '0;
        else if (commit) bright_q <= cmd.level;
    end

    // R4: brightness only moves on a commit edge.
    p_bright_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(bright_q));

    // R5: a commit edge cannot be followed directly by another commit.
    p_single_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
endmodule

// File: rtl/srl_frame.sv
// Frame store: NROWS rows of DW bits with one synchronous write port and an
// independent combinational read port. Reads of rows past the end give zero.
// Synchronous active-low reset clears every row.
module srl_frame #(
    parameter int NROWS = 20,
    parameter int DW    = 20,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [NROWS-1:0][DW-1:0] mem_q;

    for (genvar r = 0; r < NROWS; r++) begin : g_row
        // Each row takes the write data only when it is the one addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[r] <= '0;
            else if (wr_en && (wr_addr == AW'(r)))
                mem_q[r] <= wr_data;
        end
    end

    // Select the addressed row for the scan side; out-of-range reads zero.
    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NROWS; r++) begin
            if (rd_addr == AW'(r)) rd_data = mem_q[r];
        end
    end

    // R6: the commit stage never asks for a row that does not exist.
    p_addr_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < NROWS));

    // R9: without a write, no row of the store moves.
    p_rows_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem_q));

    // R8: a reset edge leaves the whole store at zero.
    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> (mem_q == '0));
endmodule

// File: rtl/serial_row_loader.sv
// Serial row loader: a shift register feeding a commit decoder that writes a
// 20x20 frame store and holds a brightness code. The read port is
// combinational and independent of loading. All logic is on sclk; strobe
// and sdata are assumed synchronous to it.
module serial_row_loader
    import srl_pkg::*;
(
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                sdata,
    input  logic                strobe,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [BRIGHT_W-1:0] bright
);
    logic [WORD_W-1:0] word;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    srl_shift #(.W(WORD_W)) u_shift (
        .clk  (sclk),
        .rst_n(rst_n),
        .din  (sdata),
        .word (word)
    );

    srl_commit #(.NROWS(ROWS)) u_commit (
        .clk    (sclk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .word   (word),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .bright (bright)
    );

    srl_frame #(.NROWS(ROWS), .DW(DATA_W), .AW(ADDR_W)) u_frame (
        .clk    (sclk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );
endmodule

// File: tb/tb_serial_row_loader.sv
`timescale 1ns/10ps
// Scoreboard bench: the driver shifts words, keeps a model of the store and
// queues one expectation per commit; the monitor pops each one and sweeps
// every row, and between items keeps watching a fixed row.
module tb_serial_row_loader;
    localparam int ROWS  = 20;
    localparam int WATCH = 3;

    typedef struct {
        int         kind;   // 0 normal, 1 out of range, 2 held strobe, 3 reset, 4 leading bits, 5 spare bits
        logic [4:0] addr;
        logic [3:0] br;
    } item_t;

    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdata = 1'b0;
    logic        strobe = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [19:0] rd_data;
    logic [3:0]  bright;

    logic [19:0] exp_mem [ROWS];
    item_t       sb_q [$];
    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;

    serial_row_loader dut (
        .sclk(sclk), .rst_n(rst_n), .sdata(sdata), .strobe(strobe),
        .rd_addr(rd_addr), .rd_data(rd_data), .bright(bright)
    );

    always #5 sclk = ~sclk;

    function automatic string tag_of(input int k);
        case (k)
            1: return "R6";
            2: return "R5";
            3: return "R8";
            4: return "R1";
            5: return "R2";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [19:0] act, input logic [19:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic shift_bit(input logic b);
        @(negedge sclk);
        sdata = b;
    endtask

    // Shift one word, raise strobe, optionally keep it high over a second word.
    task automatic send(input int kind, input logic [4:0] a, input logic [19:0] d,
                        input logic [3:0] b, input logic [2:0] spare, input bit hold);
        logic [31:0] w;
        logic [31:0] alt;
        item_t it;
        w   = {a, d, b, spare};
        alt = {5'd0, ~d, ~b, 3'b000};
        for (int i = 31; i >= 0; i--) shift_bit(w[i]);
        @(negedge sclk);
        strobe = 1'b1;
        @(posedge sclk);
        #1;
        if (a < 5'(ROWS)) exp_mem[a] = d;
        if (hold) begin
            for (int i = 31; i >= 0; i--) shift_bit(alt[i]);
        end
        @(negedge sclk);
        strobe = 1'b0;
        @(posedge sclk);
        #1;
        it.kind = kind;
        it.addr = a;
        it.br   = b;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic do_reset();
        item_t it;
        @(negedge sclk);
        rst_n = 1'b0;
        @(posedge sclk);
        #1;
        for (int r = 0; r < ROWS; r++) exp_mem[r] = '0;
        @(negedge sclk);
        rst_n = 1'b1;
        @(posedge sclk);
        #1;
        it.kind = 3;
        it.addr = '0;
        it.br   = '0;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    // Monitor: sweep on queued items, otherwise watch one row.
    initial begin
        forever begin
            @(negedge sclk);
            if (sb_q.size() > 0) begin
                item_t it;
                bit    ok_row;
                bit    ok_oth;
                logic [19:0] a_act;
                logic [19:0] a_exp;
                it = sb_q[0];
                ok_row = 1'b1;
                ok_oth = 1'b1;
                a_act = '0;
                a_exp = '0;
                check(bright === it.br, (it.kind == 1) ? "R6" : "R4",
                      "brightness", 20'(bright), 20'(it.br));
                for (int r = 0; r < ROWS; r++) begin
                    rd_addr = 5'(r);
                    #0.2;
                    if (rd_data !== exp_mem[r]) begin
                        if (5'(r) == it.addr && it.kind != 1) ok_row = 1'b0;
                        else if (ok_oth) begin
                            ok_oth = 1'b0;
                            a_act = rd_data;
                            a_exp = exp_mem[r];
                        end
                        if (5'(r) == it.addr && it.kind != 1) begin
                            a_act = rd_data;
                            a_exp = exp_mem[r];
                        end
                    end
                end
                if (it.addr < 5'(ROWS) && it.kind != 3)
                    check(ok_row, tag_of(it.kind), "addressed row", a_act, a_exp);
                check(ok_oth, (it.kind == 0) ? "R9" : tag_of(it.kind),
                      "other rows", a_act, a_exp);
                rd_addr = 5'd25;
                #0.2;
                check(rd_data === '0, "R7", "read past end", rd_data, '0);
                rd_addr = 5'(WATCH);
                void'(sb_q.pop_front());
            end else if (rst_n) begin
                rd_addr = 5'(WATCH);
                #0.2;
                check(rd_data === exp_mem[WATCH], "R7", "watched row during shift",
                      rd_data, exp_mem[WATCH]);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < ROWS; r++) exp_mem[r] = '0;
        repeat (3) @(posedge sclk);
        do_reset();                                       // R8 reset state
        send(0, 5'd5,  20'hA5F0C, 4'h9, 3'b000, 1'b0);   // R3 R4
        send(5, 5'd0,  20'h00001, 4'h1, 3'b111, 1'b0);   // R2 first row, spare bits set
        send(5, 5'd19, 20'h80000, 4'hF, 3'b101, 1'b0);   // R2 last row, MSB of data
        send(0, 5'd3,  20'h12345, 4'h6, 3'b000, 1'b0);   // R7 watched row rewritten
        send(1, 5'd20, 20'hFFFFF, 4'h2, 3'b000, 1'b0);   // R6 first bad address
        send(1, 5'd31, 20'h55555, 4'hC, 3'b011, 1'b0);   // R6 top address
        send(2, 5'd7,  20'h0F0F0, 4'h3, 3'b000, 1'b1);   // R5 held strobe
        for (int i = 0; i < 7; i++) shift_bit(1'b1);     // R1 leading bits
        send(4, 5'd12, 20'h6B1D2, 4'hA, 3'b000, 1'b0);
        send(0, 5'd5,  20'h0BEEF, 4'h4, 3'b000, 1'b0);   // R9 overwrite
        do_reset();                                       // R8 mid-run
        send(0, 5'd10, 20'hC3C3C, 4'h7, 3'b000, 1'b0);
        repeat (4) @(posedge sclk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule